// File: doc/BRIEF.md
# Boot ROM Overlay Controller

This block decodes the address and direction of an 8-bit CPU bus and steers each access to one of two memories. The first is a 256-byte loader ROM inside the block. The second is an external 16 KB EEPROM that fills the top quarter of the 64 KB address space. The topmost 256-byte page holds the reset and interrupt vectors. A small control register decides which of the two memories answers in that page. Out of reset the loader ROM answers there, so the CPU always starts from the fixed loader code.

The same register also gates writes to the EEPROM. This software write enable works alongside a hardware jumper, and either one alone can block a write. The block drives the EEPROM chip select, the EEPROM write enable and a ROM select. It also returns read data for the loader ROM and for the control register, and flags when it is driving the data bus. The loader ROM contents are computed from a fixed formula, and the ROM has no write path.

Top module: `boot_overlay_ctrl`

## Requirements
- R1: After a synchronous active-low reset the control register holds 2'b00: a read of the control register returns 8'h00, and a read in page 0xFF00–0xFFFF is served by the loader ROM.
- R2: A write cycle to the control register address 0xBF00 loads write-data bits [1:0] into the register. Bits [7:2] of the write data are discarded, and a read of 0xBF00 returns {6'b0, register}.
- R3: With register bit 1 = 0, a read in 0xFF00–0xFFFF asserts rom_sel, keeps eeprom_cs_n high, and returns loader byte i = addr[7:0], whose value is (i*37 + 17) mod 256.
- R4: With register bit 1 = 1, any access in 0xFF00–0xFFFF asserts eeprom_cs_n low, and rom_sel stays low.
- R5: Any valid access in 0xC000–0xFEFF asserts eeprom_cs_n low whatever the register holds. Accesses below 0xC000 never select the EEPROM or the ROM.
- R6: eeprom_we_n goes low only for a write cycle that selects the EEPROM while register bit 0 = 1 and wp_block = 0.
- R7: wp_block = 1 keeps eeprom_we_n high even when register bit 0 = 1. The chip select is unaffected.
- R8: A write in 0xFF00–0xFFFF while the loader ROM is overlaid asserts neither eeprom_cs_n nor eeprom_we_n nor rom_sel.
- R9: The loader ROM is read-only: a write to an overlaid address leaves its later read value unchanged.
- R10: rd_en is high exactly for reads served by the loader ROM or by the control register. Otherwise rd_data is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | A bus cycle is in progress |
| bus_rd | input | 1 | 1 = read cycle, 0 = write cycle |
| bus_addr | input | 16 | CPU address |
| bus_wdata | input | 8 | CPU write data |
| wp_block | input | 1 | Write-protect jumper; 1 blocks EEPROM writes |
| rd_data | output | 8 | Read data from loader ROM or control register |
| rd_en | output | 1 | Block is driving rd_data for this read |
| rom_sel | output | 1 | Loader ROM is answering this read |
| eeprom_cs_n | output | 1 | EEPROM chip select, active low |
| eeprom_we_n | output | 1 | EEPROM write enable, active low |

## Verification
The assertions check the following on every cycle:
- the ROM select and the EEPROM chip select are never active together;
- no write-enable pulse appears without both permissions;
- an overlaid top-page access never reaches the EEPROM;
- the control register changes only on a write to its own address, and then takes the written low bits.

The bench scenarios show what a property cannot express:
- the actual loader byte values;
- the control register readback with its upper bits cleared;
- that a discarded write leaves the ROM contents unchanged;
- how the decode switches when the overlay bit is flipped at run time.

// File: rtl/boot_overlay_pkg.sv
// Package: shared widths, memory map constants and the loader ROM content
// function for the boot ROM overlay controller.
// Assumes a 16-bit byte address and an 8-bit data bus.
package boot_overlay_pkg;
    localparam int ADDR_W    = 16;
    localparam int DATA_W    = 8;
    localparam int CTRL_W    = 2;
    localparam int ROM_AW    = 8;
    localparam int ROM_DEPTH = 1 << ROM_AW;

    // EEPROM window: top two address bits both set (0xC000-0xFFFF)
    localparam int            WIN_BITS = 2;
    localparam logic [1:0]    WIN_TAG  = 2'b11;
    // overlay page: upper byte all ones (0xFF00-0xFFFF)
    localparam int            PAGE_BITS = ADDR_W - ROM_AW;
    localparam logic [PAGE_BITS-1:0] PAGE_TAG = '1;
    // control register I/O address
    localparam logic [ADDR_W-1:0] CTRL_ADDR = 16'hBF00;

    // control register bit meanings
    localparam int BIT_WR_EN   = 0;
    localparam int BIT_EE_HIGH = 1;

    // loader byte i = (i*37 + 17) mod 256
    function automatic logic [DATA_W-1:0] loader_byte(input logic [ROM_AW-1:0] idx);
        logic [15:0] prod;
        prod = 16'(idx) * 16'd37 + 16'd17;
        return prod[DATA_W-1:0];
    endfunction
endpackage

// File: rtl/overlay_ctrl_reg.sv
// Module: two-bit overlay/write-enable control register.
// Loads the low bits of the write data on a write cycle to CTRL_ADDR and
// ignores the upper bits. Assumes the bus signals are stable around the clock edge.
module overlay_ctrl_reg
    import boot_overlay_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wdata,
    output logic [CTRL_W-1:0] ctrl_q
);
    // register update: reset clears, a write hit loads the low bits
    always_ff @(posedge clk) begin
        if (!rst_n)      ctrl_q <= '0;
        else if (wr_hit) ctrl_q <= wdata[CTRL_W-1:0];
    end

    // R2
    ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> ctrl_q == $past(wdata[CTRL_W-1:0]));

    // R1
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(ctrl_q));
endmodule

// File: rtl/overlay_addr_decode.sv
// Module: address decoder. Turns the bus cycle and the control register into
// the EEPROM chip select, the write enable and the ROM and control-register hits.
// Purely combinational; the clock and reset are used only by its assertions.
module overlay_addr_decode
    import boot_overlay_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CTRL_W-1:0] ctrl,
    input  logic              wp_block,
    output logic              rom_hit,
    output logic              ctrl_rd_hit,
    output logic              ctrl_wr_hit,
    output logic              ee_cs,
    output logic              ee_we
);
    logic in_window;
    logic in_page;
    logic overlaid;

    // region classification of the current address
    always_comb begin
        in_window = addr[ADDR_W-1 -: WIN_BITS] == WIN_TAG;
        in_page   = addr[ADDR_W-1 -: PAGE_BITS] == PAGE_TAG;
        overlaid  = in_page && !ctrl[BIT_EE_HIGH];
    end

    // chip selects and strobes for this cycle
    always_comb begin
        rom_hit     = valid && rd && overlaid;
        ctrl_rd_hit = valid && rd && (addr == CTRL_ADDR);
        ctrl_wr_hit = valid && !rd && (addr == CTRL_ADDR);
        ee_cs       = valid && in_window && !overlaid;
        ee_we       = ee_cs && !rd && ctrl[BIT_WR_EN] && !wp_block;
    end

    // R8
    overlay_no_ee_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && addr[ADDR_W-1 -: PAGE_BITS] == PAGE_TAG && !ctrl[BIT_EE_HIGH]) |-> !ee_cs && !ee_we);

    // R3
    rom_ee_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rom_hit && ee_cs));
endmodule

// File: rtl/loader_rom.sv
// Module: 256-byte read-only loader ROM. Its contents come from the package
// formula. It has no write port, so no bus cycle can change its contents.
module loader_rom
    import boot_overlay_pkg::*;
(
    input  logic [ROM_AW-1:0] idx,
    output logic [DATA_W-1:0] data
);
    logic [DATA_W-1:0] table_q [ROM_DEPTH];

    // constant contents built by generate
    for (genvar g = 0; g < ROM_DEPTH; g++) begin : g_rom
        assign table_q[g] = loader_byte(ROM_AW'(g));
    end

    // asynchronous read of the indexed byte
    always_comb data = table_q[idx];
endmodule

// File: rtl/boot_overlay_ctrl.sv
// Module: top of the boot ROM overlay controller. Connects the decoder, the
// control register and the loader ROM, and muxes the read data.
// Assumes a single-cycle bus on which the address and strobes are valid
// while bus_valid is high.
module boot_overlay_ctrl
    import boot_overlay_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              wp_block,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_en,
    output logic              rom_sel,
    output logic              eeprom_cs_n,
    output logic              eeprom_we_n
);
    logic [CTRL_W-1:0] ctrl_q;
    logic              rom_hit, ctrl_rd_hit, ctrl_wr_hit, ee_cs, ee_we;
    logic [DATA_W-1:0] rom_data;

    overlay_ctrl_reg u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_hit (ctrl_wr_hit),
        .wdata  (bus_wdata),
        .ctrl_q (ctrl_q)
    );

    overlay_addr_decode u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .valid       (bus_valid),
        .rd          (bus_rd),
        .addr        (bus_addr),
        .ctrl        (ctrl_q),
        .wp_block    (wp_block),
        .rom_hit     (rom_hit),
        .ctrl_rd_hit (ctrl_rd_hit),
        .ctrl_wr_hit (ctrl_wr_hit),
        .ee_cs       (ee_cs),
        .ee_we       (ee_we)
    );

    loader_rom u_rom (
        .idx  (bus_addr[ROM_AW-1:0]),
        .data (rom_data)
    );

    // read-data mux and output polarity
    always_comb begin
        rom_sel     = rom_hit;
        eeprom_cs_n = !ee_cs;
        eeprom_we_n = !ee_we;
        rd_en       = rom_hit || ctrl_rd_hit;
        if (rom_hit)          rd_data = rom_data;
        else if (ctrl_rd_hit) rd_data = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
        else                  rd_data = '0;
    end

    // R6
    we_permit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !eeprom_we_n |-> (ctrl_q[BIT_WR_EN] && !bus_rd && !eeprom_cs_n));

    // R7
    jumper_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wp_block |-> eeprom_we_n);
endmodule

// File: tb/sim_boot_overlay_ctrl.sv
// Directed bench for boot_overlay_ctrl: one task per scenario.
module sim_boot_overlay_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_rd = 1'b1;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        wp_block = 1'b0;
    logic [7:0]  rd_data;
    logic        rd_en, rom_sel, eeprom_cs_n, eeprom_we_n;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    boot_overlay_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .wp_block(wp_block),
        .rd_data(rd_data), .rd_en(rd_en), .rom_sel(rom_sel),
        .eeprom_cs_n(eeprom_cs_n), .eeprom_we_n(eeprom_we_n)
    );

    function automatic logic [7:0] exp_rom(input logic [7:0] i);
        logic [15:0] p;
        p = 16'(i) * 16'd37 + 16'd17;
        return p[7:0];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // present one bus cycle at a negedge; outputs settle before sampling
    task automatic drive(input logic [15:0] a, input logic rd, input logic [7:0] wd);
        @(negedge clk);
        bus_valid = 1'b1; bus_addr = a; bus_rd = rd; bus_wdata = wd;
        #5;
    endtask

    task automatic idle();
        @(negedge clk);
        bus_valid = 1'b0; bus_rd = 1'b1; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic set_ctrl(input logic [7:0] v);
        drive(16'hBF00, 1'b0, v);
        idle();
    endtask

    task automatic t_reset();
        drive(16'hBF00, 1'b1, 8'h00);
        check("R1 ctrl after reset", rd_data, 8'h00);
        drive(16'hFFFC, 1'b1, 8'h00);
        check("R1 top page to rom", {rom_sel, eeprom_cs_n}, 2'b11);
        idle();
    endtask

    task automatic t_ctrl_write();
        set_ctrl(8'hFE);
        drive(16'hBF00, 1'b1, 8'h00);
        check("R2 upper bits dropped", rd_data, 8'h02);
        check("R10 ctrl rd_en", rd_en, 1'b1);
        idle();
        set_ctrl(8'h01);
        drive(16'hBF00, 1'b1, 8'h00);
        check("R2 readback 01", rd_data, 8'h01);
        idle();
    endtask

    task automatic t_overlay_read();
        set_ctrl(8'h00);
        for (int i = 0; i < 256; i += 51) begin
            drive(16'hFF00 + 16'(i), 1'b1, 8'h00);
            check("R3 rom byte", rd_data, exp_rom(8'(i)));
            check("R3 selects", {rom_sel, eeprom_cs_n, rd_en}, 3'b111);
        end
        drive(16'hFFFF, 1'b1, 8'h00);
        check("R3 last byte", rd_data, exp_rom(8'hFF));
        idle();
    endtask

    task automatic t_ee_top();
        set_ctrl(8'h02);
        drive(16'hFFFE, 1'b1, 8'h00);
        check("R4 ee top read", {rom_sel, eeprom_cs_n, rd_en}, 3'b000);
        check("R10 no data drive", rd_data, 8'h00);
        drive(16'hFF10, 1'b0, 8'h55);
        check("R4 ee top write no we", {eeprom_cs_n, eeprom_we_n}, 2'b01);
        idle();
    endtask

    task automatic t_window();
        set_ctrl(8'h00);
        drive(16'hC000, 1'b1, 8'h00);
        check("R5 window base", {eeprom_cs_n, rom_sel}, 2'b00);
        drive(16'hFEFF, 1'b1, 8'h00);
        check("R5 window below page", {eeprom_cs_n, rom_sel}, 2'b00);
        drive(16'hBFFF, 1'b1, 8'h00);
        check("R5 below window", {eeprom_cs_n, rom_sel, rd_en}, 3'b100);
        drive(16'h0000, 1'b0, 8'h12);
        check("R5 low write", {eeprom_cs_n, eeprom_we_n}, 2'b11);
        idle();
    endtask

    task automatic t_we_gating();
        set_ctrl(8'h00);
        drive(16'hD000, 1'b0, 8'hAA);
        check("R6 bit0 clear", eeprom_we_n, 1'b1);
        idle();
        set_ctrl(8'h01);
        drive(16'hD000, 1'b0, 8'hAA);
        check("R6 write allowed", {eeprom_cs_n, eeprom_we_n}, 2'b00);
        drive(16'hD000, 1'b1, 8'h00);
        check("R6 read no we", eeprom_we_n, 1'b1);
        idle();
    endtask

    task automatic t_jumper();
        set_ctrl(8'h03);
        wp_block = 1'b1;
        drive(16'hE123, 1'b0, 8'h33);
        check("R7 jumper blocks", {eeprom_cs_n, eeprom_we_n}, 2'b01);
        drive(16'hFF00, 1'b0, 8'h33);
        check("R7 jumper top page", eeprom_we_n, 1'b1);
        idle();
        wp_block = 1'b0;
        drive(16'hFF00, 1'b0, 8'h33);
        check("R7 jumper released", eeprom_we_n, 1'b0);
        idle();
    endtask

    task automatic t_overlay_write();
        set_ctrl(8'h01);
        drive(16'hFF40, 1'b0, 8'h00);
        check("R8 discarded write", {eeprom_cs_n, eeprom_we_n, rom_sel}, 3'b110);
        idle();
        drive(16'hFF40, 1'b1, 8'h00);
        check("R9 rom unchanged", rd_data, exp_rom(8'h40));
        idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ctrl_write();
        t_overlay_read();
        t_ee_top();
        t_window();
        t_we_gating();
        t_jumper();
        t_overlay_write();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule